// File: doc/BRIEF.md
# Serial Bias Control Shift Register

This block is the receiving end of a three-wire synchronous serial link that programs eight control bits on a four-amplifier bias card. While its own active-low select line is held low, each rising edge of the serial clock moves one data bit into an internal byte, most significant bit first. When the select line goes high again, the byte is accepted only if exactly eight bits arrived. The upper nibble then drives the select inputs of the monitor multiplexers, and the lower nibble turns bias on or off for each amplifier. The serial clock and data wires also run to a converter that has its own select line. Traffic meant for that converter therefore passes this block without effect, as long as this block's select stays high.

The serial wires are slow compared with the system clock. They are brought into the system clock domain through a short synchronizer, and their edges are detected there. A supply-fault input forces the safe state at any time: monitor select zero and every amplifier off. Reset forces the same state. A one-cycle pulse marks each accepted byte.

Top module: `bias_ctl_shreg`

## Requirements
- R1: While `rst` is high at a clock edge, `mon_sel_o`, `amp_en_o` and `commit_o` are all zero after that edge.
- R2: Data is sampled on each rising edge of `ser_clk_i` while `ser_sel_n_i` is low, first bit sent = bit 7. When a frame of exactly eight bits is accepted, bits 7..4 appear on `mon_sel_o[3:0]` and bits 3..0 appear on `amp_en_o[3:0]`, with bit 0 controlling amplifier 1. An enable value of 1 means bias on.
- R3: The outputs change only when a byte is accepted, on fault or on reset. Serial clock edges while `ser_sel_n_i` is high have no effect.
- R4: A frame with fewer than or more than eight serial clock edges is discarded, and the outputs keep their previous value.
- R5: At every clock edge where `supply_fault_i` is high, the outputs become zero and no byte is accepted.
- R6: A fault that arrives during a frame discards the bits received so far. Serial edges that arrive while the fault is high are not counted.
- R7: `commit_o` is high for exactly one clock cycle for each accepted byte.
- R8: The outputs and `commit_o` change at the third system clock edge that sees `ser_sel_n_i` high after the frame. This timing holds for the default two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, shared with the converter |
| ser_dat_i | input | 1 | Serial data, shared with the converter |
| ser_sel_n_i | input | 1 | Active-low select for this register |
| supply_fault_i | input | 1 | Supply undervoltage flag, active high, synchronous to `clk` |
| mon_sel_o | output | 4 | Monitor multiplexer select code |
| amp_en_o | output | 4 | Per-amplifier bias enable, bit 0 = amplifier 1 |
| commit_o | output | 1 | One-cycle pulse when a new byte is accepted |

## Verification
A supply fault can arrive in the same cycle as a frame completion, that is, when the synchronized select edge would accept a byte. It can also arrive in the middle of a frame. The bench raises the fault exactly on the edge where acceptance is due, and also partway through a frame that later completes its remaining bits. In both cases the outputs must read zero and no pulse may appear. A bench model built from history queues predicts the outputs and the pulse on every clock cycle.

// File: rtl/bias_ctl_pkg.sv
package bias_ctl_pkg;

  // Control word layout: monitor select in the upper field, enables below.
  localparam int SEL_W   = 4;
  localparam int N_AMP   = 4;
  localparam int WORD_W  = SEL_W + N_AMP;

  typedef struct packed {
    logic [SEL_W-1:0] mon_sel;
    logic [N_AMP-1:0] amp_en;
  } bias_word_t;

  // Index of each serial line inside the synchronized bundle.
  localparam int LN_CLK = 0;
  localparam int LN_DAT = 1;
  localparam int LN_SEL = 2;
  localparam int N_LINES = 3;

endpackage

// File: rtl/bias_ctl_sync.sv
module bias_ctl_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= IDLE;
          else     stg[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= IDLE;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/bias_ctl_frame_rx.sv
module bias_ctl_frame_rx #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fault_i,
  input  logic               sclk_s,
  input  logic               sdat_s,
  input  logic               ssel_n_s,
  output logic [FRAME_W-1:0] data_o,
  output logic               done_o
);

  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             sclk_q;
  logic             ssel_n_q;
  logic [CNT_W-1:0] cnt;
  logic [FRAME_W-1:0] shreg;
  logic             clk_rise;
  logic             sel_rise;

  assign clk_rise = sclk_s & ~sclk_q;
  assign sel_rise = ssel_n_s & ~ssel_n_q;

  // Edge-detect history follows the lines even during a fault.
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      ssel_n_q <= 1'b1;
    end else begin
      sclk_q   <= sclk_s;
      ssel_n_q <= ssel_n_s;
    end
  end

  // Bit counter saturates one past a full frame so long frames stay invalid.
  always_ff @(posedge clk) begin
    if (rst || fault_i || ssel_n_s) begin
      cnt <= '0;
    end else if (clk_rise && cnt != CNT_W'(CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (!fault_i && !ssel_n_s && clk_rise) begin
      shreg <= {shreg[FRAME_W-2:0], sdat_s};
    end
  end

  assign data_o = shreg;
  assign done_o = sel_rise & ~fault_i & (cnt == CNT_W'(FRAME_W));

endmodule

// File: rtl/bias_ctl_out_reg.sv
module bias_ctl_out_reg
  import bias_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fault_i,
  input  logic       load_i,
  input  bias_word_t word_i,
  output bias_word_t word_o,
  output logic       commit_o
);

  always_ff @(posedge clk) begin
    if (rst || fault_i) begin
      word_o   <= '0;
      commit_o <= 1'b0;
    end else begin
      commit_o <= load_i;
      if (load_i) word_o <= word_i;
    end
  end

endmodule

// File: rtl/bias_ctl_shreg.sv
module bias_ctl_shreg
  import bias_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_sel_n_i,
  input  logic             supply_fault_i,
  output logic [SEL_W-1:0] mon_sel_o,
  output logic [N_AMP-1:0] amp_en_o,
  output logic             commit_o
);

  localparam logic [N_LINES-1:0] IDLE_LINES = N_LINES'(1) << LN_SEL;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] syn_lines;
  logic [WORD_W-1:0]  rx_data;
  logic               rx_done;
  bias_word_t         word_q;

  assign raw_lines[LN_CLK] = ser_clk_i;
  assign raw_lines[LN_DAT] = ser_dat_i;
  assign raw_lines[LN_SEL] = ser_sel_n_i;

  bias_ctl_sync #(
    .W(N_LINES), .STAGES(SYNC_STAGES), .IDLE(IDLE_LINES)
  ) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_lines), .q_o(syn_lines)
  );

  bias_ctl_frame_rx #(.FRAME_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .fault_i(supply_fault_i),
    .sclk_s(syn_lines[LN_CLK]), .sdat_s(syn_lines[LN_DAT]),
    .ssel_n_s(syn_lines[LN_SEL]),
    .data_o(rx_data), .done_o(rx_done)
  );

  bias_ctl_out_reg u_out (
    .clk(clk), .rst(rst), .fault_i(supply_fault_i),
    .load_i(rx_done), .word_i(bias_word_t'(rx_data)),
    .word_o(word_q), .commit_o(commit_o)
  );

  assign mon_sel_o = word_q.mon_sel;
  assign amp_en_o  = word_q.amp_en;

endmodule

// File: rtl/bias_ctl_shreg_chk.sv
module bias_ctl_shreg_chk
  import bias_ctl_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ser_clk_i,
  input logic             ser_dat_i,
  input logic             ser_sel_n_i,
  input logic             supply_fault_i,
  input logic [SEL_W-1:0] mon_sel_o,
  input logic [N_AMP-1:0] amp_en_o,
  input logic             commit_o
);

  assert_reset_safe_R1: assert property (@(posedge clk)
    rst |=> (mon_sel_o == '0 && amp_en_o == '0 && !commit_o));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!commit_o && !$past(supply_fault_i)) |-> $stable({mon_sel_o, amp_en_o}));

  assert_fault_clear_R5: assert property (@(posedge clk) disable iff (rst)
    supply_fault_i |=> (mon_sel_o == '0 && amp_en_o == '0 && !commit_o));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !commit_o);

  assert_commit_after_select_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(commit_o) |-> $past(ser_sel_n_i));

endmodule

bind bias_ctl_shreg bias_ctl_shreg_chk u_chk (.*);

// File: tb/bias_ctl_shreg_test.sv
module bias_ctl_shreg_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0;
  logic       sdat = 1'b0;
  logic       ssel_n = 1'b1;
  logic       fault = 1'b0;
  logic [3:0] mon_sel;
  logic [3:0] amp_en;
  logic       commit;

  int n_checks = 0;
  int n_fail = 0;
  int n_pulses = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  bias_ctl_shreg uut (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_dat_i(sdat),
    .ser_sel_n_i(ssel_n), .supply_fault_i(fault),
    .mon_sel_o(mon_sel), .amp_en_o(amp_en), .commit_o(commit)
  );

  // Behavioural reference: line history in queues, two-edge input delay.
  int qc[$];
  int qd[$];
  int qn[$];
  int m_out = 0;
  int m_sh = 0;
  int m_cnt = 0;
  int m_com = 0;

  always @(posedge clk) begin
    if (rst) begin
      qc = '{0, 0, 0, 0};
      qd = '{0, 0, 0, 0};
      qn = '{1, 1, 1, 1};
      m_out = 0; m_sh = 0; m_cnt = 0; m_com = 0;
    end else begin
      qc.push_front(int'(sclk)); qd.push_front(int'(sdat)); qn.push_front(int'(ssel_n));
      void'(qc.pop_back()); void'(qd.pop_back()); void'(qn.pop_back());
      if (fault) begin
        m_out = 0; m_cnt = 0; m_com = 0;
      end else begin
        m_com = 0;
        if (qn[2] == 1) begin
          if (qn[3] == 0 && m_cnt == 8) begin
            m_out = m_sh; m_com = 1;
          end
          m_cnt = 0;
        end else if (qc[2] == 1 && qc[3] == 0) begin
          m_sh = ((m_sh << 1) | qd[2]) & 255;
          if (m_cnt < 9) m_cnt++;
        end
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      n_checks++;
      if ({mon_sel, amp_en} != m_out[7:0]) begin
        n_fail++;
        $display("FAIL R3 model compare: outputs %h expected %h", {mon_sel, amp_en}, m_out[7:0]);
      end
      n_checks++;
      if (int'(commit) != m_com) begin
        n_fail++;
        $display("FAIL R7 model compare: commit %0d expected %0d", commit, m_com);
      end
      if (commit) n_pulses++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i];
      sclk = 1'b0; wait_cyc(3);
      sclk = 1'b1; wait_cyc(3);
    end
    sclk = 1'b0; wait_cyc(3);
  endtask

  task automatic send_frame(input logic [15:0] bits, input int n);
    @(negedge clk);
    ssel_n = 1'b0; wait_cyc(3);
    shift_bits(bits, n);
    ssel_n = 1'b1; wait_cyc(6);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done_flag = 1'b1;
    summary();
    $finish;
  end

  initial begin
    int p0;
    wait_cyc(4);
    check("R1 reset mon_sel", int'(mon_sel), 0);
    check("R1 reset amp_en", int'(amp_en), 0);
    check("R1 reset commit", int'(commit), 0);
    rst = 1'b0; wait_cyc(3);

    // R2: field placement, MSB first
    p0 = n_pulses;
    send_frame(16'h00A5, 8);
    check("R2 mon_sel from bits 7..4", int'(mon_sel), 'hA);
    check("R2 amp_en from bits 3..0", int'(amp_en), 'h5);
    check("R7 one pulse per byte", n_pulses - p0, 1);
    send_frame(16'h003C, 8);
    check("R2 second byte", int'({mon_sel, amp_en}), 'h3C);

    // R3: serial clocks for the other device, select high
    sdat = 1'b1; shift_bits(16'hFFFF, 8); wait_cyc(4);
    check("R3 ignored while deselected", int'({mon_sel, amp_en}), 'h3C);

    // R4: short and long frames
    p0 = n_pulses;
    send_frame(16'h00FF, 7);
    check("R4 seven-bit frame dropped", int'({mon_sel, amp_en}), 'h3C);
    send_frame(16'h01FF, 9);
    check("R4 nine-bit frame dropped", int'({mon_sel, amp_en}), 'h3C);
    check("R4 no pulse on bad frames", n_pulses - p0, 0);

    // R8: latency after the select rises
    @(negedge clk); ssel_n = 1'b0; wait_cyc(3);
    shift_bits(16'h0081, 8);
    ssel_n = 1'b1;
    wait_cyc(2);
    check("R8 unchanged after two edges", int'({mon_sel, amp_en}), 'h3C);
    wait_cyc(1);
    check("R8 updated at third edge", int'({mon_sel, amp_en}), 'h81);
    check("R8 pulse at third edge", int'(commit), 1);
    wait_cyc(1);
    check("R7 pulse gone next cycle", int'(commit), 0);
    wait_cyc(4);

    // R5: fault clears outputs
    fault = 1'b1; wait_cyc(1);
    check("R5 fault clears outputs", int'({mon_sel, amp_en}), 0);
    wait_cyc(3);
    check("R5 held while fault", int'({mon_sel, amp_en}), 0);
    fault = 1'b0; wait_cyc(2);

    // R5: fault on the accepting edge
    send_frame(16'h0077, 8);
    @(negedge clk); ssel_n = 1'b0; wait_cyc(3);
    shift_bits(16'h00E2, 8);
    ssel_n = 1'b1; wait_cyc(2);
    fault = 1'b1; wait_cyc(1);
    check("R5 no accept under fault", int'({mon_sel, amp_en}), 0);
    check("R5 no pulse under fault", int'(commit), 0);
    fault = 1'b0; wait_cyc(6);

    // R6: fault mid-frame discards partial bits
    send_frame(16'h0012, 8);
    check("R6 setup byte", int'({mon_sel, amp_en}), 'h12);
    @(negedge clk); ssel_n = 1'b0; wait_cyc(3);
    shift_bits(16'h000F, 4);
    fault = 1'b1;
    shift_bits(16'h0003, 2);
    fault = 1'b0;
    shift_bits(16'h000A, 4);
    ssel_n = 1'b1; wait_cyc(6);
    check("R6 partial frame dropped", int'({mon_sel, amp_en}), 0);
    send_frame(16'h00C3, 8);
    check("R6 next full frame accepted", int'({mon_sel, amp_en}), 'hC3);

    done_flag = 1'b1;
    summary();
    $finish;
  end

endmodule